// File: doc/BRIEF.md
# Register-Mapped Serial Transmitter with Receive Buffering

This block connects a processor's simple synchronous register bus to an asynchronous serial line. Software programs a control byte and a 13-bit clock divisor, polls or takes an interrupt on a status byte, and moves characters through one shared data address. Writes to that address feed a transmit holding register. Reads from it return the oldest received character.

Internally a divider makes a tick at sixteen times the bit rate. The transmitter moves a byte from the holding register into a shift register and drives the line. The line rests high; each frame has a low start bit, the data least significant bit first, an optional ninth bit, and a high stop bit. Received bytes arrive from a separate deserialiser as one-cycle valid pulses. A single backup slot lets a second byte wait behind an unread one, and a third byte in that state is dropped and reported as an overrun.

The transmit-empty, receive-full and overrun flags are protected against stray accesses. A flag clears only when software first reads the status byte while the flag is set and then makes the matching data access. The interrupt line combines each of the two main flags with its own enable bit.

Top module: `uart_regif`

## Requirements
- R1: After reset, status reads 0x01 (only transmit-empty set), the control byte and both divisor bytes read 0, `txd` is high and `irq` is low.
- R2: The address map is 0 = control, 1 = divisor high (bits 4:0 are divisor bits 12:8), 2 = divisor low, 3 = status, 4 = data. Control and divisor bytes read back as last written. Status bit 0 = transmit-empty, bit 1 = receive-full, bit 2 = overrun, and the other bits read 0. Writes to status have no effect. `rdata` is valid in the cycle after the read strobe.
- R3: Each serial bit lasts 16 × divisor clock cycles. A divisor of 0 stops the bit clock, so the line holds its current level.
- R4: In 8-bit mode (control bit 4 = 0) a frame is a low start bit, the 8 data bits least significant first, and then a high stop bit.
- R5: In 9-bit mode (control bit 4 = 1), control bit 5 is sent as a ninth data bit between the eighth data bit and the stop bit.
- R6: `txd` is high whenever the transmitter is idle. It is also high from the cycle after transmit-enable (control bit 0) goes low, which abandons any frame in progress.
- R7: Transmit-empty clears only on a data write that follows a status read which returned it set. A data write without that status read leaves the flag set, and no frame is sent.
- R8: While transmit-enable is set, a full holding register moves into an idle shift register, which sets transmit-empty again. A second byte written during a frame is sent directly after it.
- R9: A valid pulse with receive-enable (control bit 1) set stores the byte and sets receive-full. With receive-enable clear the pulse is ignored.
- R10: Receive-full clears only on a data read that follows a status read which returned it set. A data read alone leaves it set.
- R11: A byte arriving while receive-full is set waits in a backup slot and replaces the register when the register is cleared, so receive-full stays set. A byte arriving while both are occupied is dropped and sets overrun. Overrun clears on a data read that follows a status read showing it set.
- R12: A byte that arrives in the same cycle as the clearing data read is stored, and receive-full stays set.
- R13: `irq` = (control bit 2 AND transmit-empty) OR (control bit 3 AND receive-full).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| rx_valid | input | 1 | One-cycle pulse from the receiver core with a completed byte |
| rx_data | input | 8 | Received byte |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
The receive path can take a new byte in the same cycle that software's clearing data read empties the register, and the bench provokes this by raising `rx_valid` together with the data read strobe. It is judged by the read returning the old byte while status still shows receive-full and the next read returning the new byte. The same cycle is also provoked with the backup slot occupied, where the backup byte must move forward and the arriving byte take its place without an overrun. On the transmit side, a second byte is queued while a frame is being shifted out, and the captured waveform must show both frames back to back with their bits aligned to the programmed period.

// File: rtl/uart_regif_pkg.sv
// Package: register addresses and the control byte layout shared by the
// serial register controller and its checker. Assumes a 3-bit address bus.
package uart_regif_pkg;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIV_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIV_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATA   = 3'd4;

    // Control byte, bit 0 at the bottom.
    typedef struct packed {
        logic [1:0] spare;
        logic       tx_bit8;
        logic       nine;
        logic       rx_arm;
        logic       tx_arm;
        logic       rx_on;
        logic       tx_on;
    } ctrl_t;
endpackage

// File: rtl/uart_baud_gen.sv
// Oversample tick generator: pulses `tick` once every `div` clocks.
// Assumes div may change at any time; a divisor of zero holds it silent.
module uart_baud_gen #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count down from div-1 and pulse when reloading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (div == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= div - DIV_W'(1);
            tick <= 1'b1;
        end else begin
            cnt  <= cnt - DIV_W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_shift.sv
// Transmit shifter: takes a byte from the holding register when idle,
// frames it with start, optional ninth and stop bits, and shifts it out
// LSB first, one bit every OSR ticks. Assumes tick comes from the divider.
module uart_tx_shift #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              nine,
    input  logic              bit8,
    input  logic              hold_empty,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              txd
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int SUB_W   = $clog2(OSR);

    logic               busy;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   left;
    logic [SUB_W-1:0]   sub;

    assign take = tx_en && !busy && !hold_empty;
    assign txd  = busy ? shreg[0] : 1'b1;

    // Load a frame, then step one bit per OSR ticks until it is gone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
            sub   <= '0;
        end else if (!tx_en) begin
            busy <= 1'b0;
            sub  <= '0;
        end else if (take) begin
            busy  <= 1'b1;
            sub   <= '0;
            shreg <= {1'b1, (nine ? bit8 : 1'b1), hold_data, 1'b0};
            left  <= nine ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
        end else if (busy && tick) begin
            if (sub == SUB_W'(OSR - 1)) begin
                sub   <= '0;
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                left  <= left - CNT_W'(1);
                if (left == CNT_W'(1)) busy <= 1'b0;
            end else begin
                sub <= sub + SUB_W'(1);
            end
        end
    end
endmodule

// File: rtl/uart_rx_buf.sv
// Receive side: a data register plus one backup slot, the receive-full
// and overrun flags, and their status-read-then-data-read clear rule.
// Assumes rx_valid is a single-cycle pulse per completed byte.
module uart_rx_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              st_rd,
    input  logic              dat_rd,
    output logic [DATA_W-1:0] rdr,
    output logic              full,
    output logic              ovr,
    output logic              hold_v
);
    logic [DATA_W-1:0] hold;
    logic              arm_full;
    logic              arm_ovr;
    logic              accept;
    logic              clr_full;
    logic              clr_ovr;

    assign accept   = rx_valid && rx_en;
    assign clr_full = dat_rd && arm_full && full;
    assign clr_ovr  = dat_rd && arm_ovr && ovr;

    // Remember which flags the last status read saw set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_full <= 1'b0;
            arm_ovr  <= 1'b0;
        end else if (st_rd) begin
            arm_full <= full;
            arm_ovr  <= ovr;
        end else if (dat_rd) begin
            arm_full <= 1'b0;
            arm_ovr  <= 1'b0;
        end
    end

    // Move bytes between the arriving pulse, the backup slot and the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr    <= '0;
            hold   <= '0;
            full   <= 1'b0;
            hold_v <= 1'b0;
        end else if (clr_full) begin
            if (hold_v) begin
                rdr    <= hold;
                hold_v <= accept;
                if (accept) hold <= rx_data;
            end else begin
                full <= accept;
                if (accept) rdr <= rx_data;
            end
        end else if (accept) begin
            if (!full) begin
                rdr  <= rx_data;
                full <= 1'b1;
            end else if (!hold_v) begin
                hold   <= rx_data;
                hold_v <= 1'b1;
            end
        end
    end

    // Set overrun on a third byte, clear it by the two-step access.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    ovr <= 1'b0;
        else if (accept && full && hold_v && !clr_full) ovr <= 1'b1;
        else if (clr_ovr)                              ovr <= 1'b0;
    end
endmodule

// File: rtl/uart_regif.sv
// Register-mapped serial controller top: bus decode, control and divisor
// registers, transmit holding register with its empty flag, and interrupt.
// Assumes single-cycle strobes; rdata is registered one cycle after rd_en.
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int DIV_W   = 13,
    parameter int OSR     = 16,
    parameter bit IRQ_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              txd,
    output logic              irq
);
    localparam int HI_W = DIV_W - BYTE_W;

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] div_hi;
    logic [BYTE_W-1:0] div_lo;
    logic [DIV_W-1:0]  divisor;
    logic [BYTE_W-1:0] tx_hold;
    logic              tx_empty;
    logic              arm_tx;
    logic              tx_take;
    logic              tick;
    logic              rx_full;
    logic              rx_ovr;
    logic              rx_hold_v;
    logic [BYTE_W-1:0] rx_reg;
    logic              st_rd;
    logic              dat_rd;
    logic              dat_wr;
    logic              irq_d;

    assign st_rd   = rd_en && (addr == A_STAT);
    assign dat_rd  = rd_en && (addr == A_DATA);
    assign dat_wr  = wr_en && (addr == A_DATA);
    assign divisor = {div_hi[HI_W-1:0], div_lo};

    // Control and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_hi <= '0;
            div_lo <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL:   ctrl_q <= ctrl_t'(wdata);
                A_DIV_HI: div_hi <= wdata;
                A_DIV_LO: div_lo <= wdata;
                default: ;
            endcase
        end
    end

    // Holding register takes every data write.
    always_ff @(posedge clk) begin
        if (!rst_n)      tx_hold <= '0;
        else if (dat_wr) tx_hold <= wdata;
    end

    // Latch whether the last status read saw transmit-empty set.
    always_ff @(posedge clk) begin
        if (!rst_n)      arm_tx <= 1'b0;
        else if (st_rd)  arm_tx <= tx_empty;
        else if (dat_wr) arm_tx <= 1'b0;
    end

    // Transmit-empty: set on hand-off to the shifter, cleared by the two-step.
    always_ff @(posedge clk) begin
        if (!rst_n)                             tx_empty <= 1'b1;
        else if (tx_take)                       tx_empty <= 1'b1;
        else if (dat_wr && arm_tx && tx_empty)  tx_empty <= 1'b0;
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                A_CTRL:   rdata <= BYTE_W'(ctrl_q);
                A_DIV_HI: rdata <= div_hi;
                A_DIV_LO: rdata <= div_lo;
                A_STAT:   rdata <= {5'b0, rx_ovr, rx_full, tx_empty};
                A_DATA:   rdata <= rx_reg;
                default:  rdata <= '0;
            endcase
        end
    end

    assign irq_d = (ctrl_q.tx_arm && tx_empty) || (ctrl_q.rx_arm && rx_full);

    generate
        if (IRQ_REG) begin : g_irq_reg
            logic irq_q;
            // Optional output flop on the interrupt line.
            always_ff @(posedge clk) begin
                if (!rst_n) irq_q <= 1'b0;
                else        irq_q <= irq_d;
            end
            assign irq = irq_q;
        end else begin : g_irq_comb
            assign irq = irq_d;
        end
    endgenerate

    uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (divisor),
        .tick (tick)
    );

    uart_tx_shift #(.DATA_W(BYTE_W), .OSR(OSR)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .tx_en     (ctrl_q.tx_on),
        .nine      (ctrl_q.nine),
        .bit8      (ctrl_q.tx_bit8),
        .hold_empty(tx_empty),
        .hold_data (tx_hold),
        .take      (tx_take),
        .txd       (txd)
    );

    uart_rx_buf #(.DATA_W(BYTE_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_en   (ctrl_q.rx_on),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .st_rd   (st_rd),
        .dat_rd  (dat_rd),
        .rdr     (rx_reg),
        .full    (rx_full),
        .ovr     (rx_ovr),
        .hold_v  (rx_hold_v)
    );
endmodule

// File: rtl/uart_regif_chk.sv
// Checker for uart_regif: temporal rules on the flags, the line and the
// bit clock. Attached to every instance of the top through bind.
module uart_regif_chk
    import uart_regif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic              rx_valid,
    input logic              txd,
    input logic              tx_on,
    input logic              rx_on,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              rx_ovr,
    input logic              rx_hold_v,
    input logic              div_zero,
    input logic              tick
);
    AST_TXD_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |=> txd); // R6
    AST_TX_EMPTY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_en && addr == A_DATA)); // R7
    AST_RX_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(rx_valid && rx_on)); // R9
    AST_RX_FULL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(rd_en && addr == A_DATA)); // R10
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $past(rx_valid && rx_full && rx_hold_v)); // R11
    AST_TICK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |=> !tick); // R3
endmodule

bind uart_regif uart_regif_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .rx_valid (rx_valid),
    .txd      (txd),
    .tx_on    (ctrl_q.tx_on),
    .rx_on    (ctrl_q.rx_on),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .rx_ovr   (rx_ovr),
    .rx_hold_v(rx_hold_v),
    .div_zero (divisor == '0),
    .tick     (tick)
);

// File: tb/sim_uart_regif.sv
// Bench for uart_regif: register sweeps, captured frames at two divisors,
// receive buffering corners and an exhaustive interrupt table.
module sim_uart_regif;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       txd;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int div_now = 2;

    always #2 clk = ~clk;

    uart_regif u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .txd(txd), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); rx_valid = 1'b1; rx_data = d;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    // Data read in the same cycle as an arriving byte.
    task automatic rd_push(input logic [7:0] nb, output logic [7:0] d);
        @(negedge clk); addr = 3'd4; rd_en = 1'b1; rx_valid = 1'b1; rx_data = nb;
        @(negedge clk); rd_en = 1'b0; rx_valid = 1'b0; d = rdata;
    endtask

    // Two-step transmit: poll status until empty, then write.
    task automatic tx_send(input logic [7:0] d);
        logic [7:0] s;
        s = 8'h00;
        for (int k = 0; k < 4000 && !s[0]; k++) brd(3'd3, s);
        bwr(3'd4, d);
    endtask

    task automatic set_div(input int dv);
        div_now = dv;
        bwr(3'd1, 8'((dv >> 8) & 31));
        bwr(3'd2, 8'(dv & 255));
    endtask

    // Wait for a start edge, sample each bit at its middle.
    task automatic capture(input int nb, output logic [10:0] bits);
        int per;
        int k;
        per = 16 * div_now;
        bits = '1;
        k = 0;
        while (txd !== 1'b0 && k < 5000) begin @(negedge clk); k++; end
        repeat (per / 2) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < nb; i++) begin
            repeat (per) @(negedge clk);
            bits[i] = txd;
        end
    endtask

    function automatic logic [10:0] frame_exp(input logic [7:0] d, input bit nine, input bit b8);
        logic [10:0] f;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) f[i+1] = d[i];
        if (nine) f[9] = b8;
        return f;
    endfunction

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0]  v;
        logic [10:0] fr;
        int          low_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 txd", txd, 1);
        chk("R1 irq", irq, 0);
        brd(3'd3, v); chk("R1 status", v, 8'h01);
        brd(3'd0, v); chk("R1 ctrl", v, 0);
        brd(3'd1, v); chk("R1 div hi", v, 0);
        brd(3'd2, v); chk("R1 div lo", v, 0);

        // R2 divisor readback sweep and status write ignored
        for (int i = 0; i < 13; i++) begin
            set_div(1 << i);
            brd(3'd1, v); chk("R2 div hi", v, ((1 << i) >> 8) & 31);
            brd(3'd2, v); chk("R2 div lo", v, (1 << i) & 255);
        end
        bwr(3'd0, 8'h35); brd(3'd0, v); chk("R2 ctrl readback", v, 8'h35);
        bwr(3'd0, 8'h00);
        bwr(3'd3, 8'hFE); brd(3'd3, v); chk("R2 status write ignored", v, 8'h01);

        // R4 R3 frames at divisor 2
        set_div(2);
        bwr(3'd0, 8'h01);
        for (int i = 0; i < 12; i++) begin
            logic [7:0] d;
            d = (i == 10) ? 8'h00 : (i == 11) ? 8'hFF : 8'((i * 37 + 5) & 255);
            tx_send(d);
            capture(10, fr);
            chk("R4 frame div2", int'(fr[9:0]), int'(frame_exp(d, 0, 0) & 11'h3FF));
        end

        // R7 write without status read: flag stays, nothing sent
        repeat (40) @(negedge clk);
        bwr(3'd4, 8'h3C);
        low_seen = 0;
        for (int k = 0; k < 80; k++) begin @(negedge clk); if (!txd) low_seen = 1; end
        chk("R7 no frame after unarmed write", low_seen, 0);
        brd(3'd3, v); chk("R7 empty still set", v & 1, 1);

        // R8 back-to-back frames, empty set again during first frame
        tx_send(8'h96);
        repeat (4) @(negedge clk);
        brd(3'd3, v); chk("R8 empty after hand-off", v & 1, 1);
        fork
            capture(10, fr);
            begin repeat (30) @(negedge clk); tx_send(8'h4B); end
        join
        chk("R8 first frame", int'(fr[9:0]), int'(frame_exp(8'h96, 0, 0) & 11'h3FF));
        capture(10, fr);
        chk("R8 second frame", int'(fr[9:0]), int'(frame_exp(8'h4B, 0, 0) & 11'h3FF));

        // R3 divisor 3
        repeat (60) @(negedge clk);
        set_div(3);
        tx_send(8'hC3);
        capture(10, fr);
        chk("R3 frame div3", int'(fr[9:0]), int'(frame_exp(8'hC3, 0, 0) & 11'h3FF));

        // R5 nine-bit mode with both ninth-bit values
        repeat (60) @(negedge clk);
        for (int b = 0; b < 2; b++) begin
            bwr(3'd0, b ? 8'h31 : 8'h11);
            tx_send(8'h5A);
            capture(11, fr);
            chk("R5 nine-bit frame", int'(fr), int'(frame_exp(8'h5A, 1, b[0])));
            repeat (60) @(negedge clk);
        end
        bwr(3'd0, 8'h01);

        // R3 divisor zero freezes the start bit; R6 disable releases the line
        set_div(0);
        tx_send(8'h00);
        repeat (300) @(negedge clk);
        chk("R3 div0 line held", txd, 0);
        bwr(3'd0, 8'h00);
        @(negedge clk);
        chk("R6 line high when disabled", txd, 1);
        set_div(2);

        // R9 receive disabled ignores pulses
        push(8'h11);
        brd(3'd3, v); chk("R9 ignored when off", v & 2, 0);

        // R9 R10 receive sweep with a lone data read first
        bwr(3'd0, 8'h02);
        for (int i = 0; i < 6; i++) begin
            logic [7:0] d;
            d = 8'((i * 53 + 9) & 255);
            push(d);
            brd(3'd4, v); chk("R9 data", v, d);
            brd(3'd3, v); chk("R10 full after lone read", v & 2, 2);
            brd(3'd4, v); chk("R10 data again", v, d);
            brd(3'd3, v); chk("R10 cleared", v & 2, 0);
        end

        // R11 backup slot and overrun
        push(8'hA1); push(8'hB2); push(8'hC3);
        brd(3'd3, v); chk("R11 full and overrun", v, 8'h07);
        brd(3'd4, v); chk("R11 first byte", v, 8'hA1);
        brd(3'd3, v); chk("R11 backup moved, overrun clear", v, 8'h03);
        brd(3'd4, v); chk("R11 second byte", v, 8'hB2);
        brd(3'd3, v); chk("R11 empty after both", v, 8'h01);

        // R12 arrival in the clearing cycle, backup slot empty
        push(8'h21);
        brd(3'd3, v);
        rd_push(8'h43, v); chk("R12 old byte returned", v, 8'h21);
        brd(3'd3, v); chk("R12 full stays", v, 8'h03);
        brd(3'd4, v); chk("R12 new byte", v, 8'h43);
        brd(3'd3, v); chk("R12 empty", v, 8'h01);

        // R12 arrival in the clearing cycle, backup slot occupied
        push(8'h61); push(8'h72);
        brd(3'd3, v);
        rd_push(8'h83, v); chk("R12 oldest returned", v, 8'h61);
        brd(3'd3, v); chk("R12 no overrun", v, 8'h03);
        brd(3'd4, v); chk("R12 backup byte", v, 8'h72);
        brd(3'd3, v);
        brd(3'd4, v); chk("R12 arriving byte", v, 8'h83);
        brd(3'd3, v); chk("R12 drained", v, 8'h01);

        // R13 exhaustive interrupt table
        for (int t = 1; t >= 0; t--) begin
            if (t == 0) begin brd(3'd3, v); bwr(3'd4, 8'h77); end
            for (int r = 0; r < 2; r++) begin
                if (r == 1) push(8'h99);
                for (int a = 0; a < 4; a++) begin
                    bwr(3'd0, 8'(8'h02 | (a << 2)));
                    @(negedge clk);
                    chk("R13 irq", irq, ((a & 1) && t) || ((a & 2) && r));
                end
                if (r == 1) begin brd(3'd3, v); brd(3'd4, v); end
            end
        end
        bwr(3'd0, 8'h01);
        capture(10, fr);
        chk("R8 pending byte sent on enable", int'(fr[9:0]), int'(frame_exp(8'h77, 0, 0) & 11'h3FF));
        repeat (40) @(negedge clk);
        finish_run();
    end
endmodule